// File: doc/BRIEF.md
# Two-Channel Converter Serial Master

This block is the host side of a three-wire link to a two-input successive-approximation converter. It runs conversions back to back. It divides the system clock down to a serial clock and pulls an active-low select line to open each frame. During the frame it shifts a channel request out to the converter and shifts a 16-bit result back in. Each frame does two jobs. It returns the result of the conversion requested in the previous frame, and it carries the request for the next conversion.

When a frame closes, the master checks the returned word. The word has a fixed layout: two zero bits, then the channel tag, then the mode tag, then the sample MSB first. In the 10-bit variant the sample is followed by two zero bits. The master also remembers which channel it asked for in the previous frame and compares that with the returned tag. A word that passes both checks is offered on a valid/ready port as a 12-bit sample with its two tags; 10-bit samples are left-aligned. A word that fails raises a one-cycle error flag and is dropped.

The master holds off the next frame while a sample waits to be taken, and it always keeps the select line high for a set number of system clocks between frames.

Top module: `adc2_serial_master`

## Requirements
- R1: While `rstN` is low and right after it rises, `csN` and `sclk` are high and `outValid` is low.
- R2: While `csN` is low, every level of `sclk`, including the first low level after `csN` falls, lasts exactly `HALF_DIV` system clocks. Each frame holds exactly 16 falling and 16 rising `sclk` edges. `sclk` is high whenever `csN` is high.
- R3: The 16 bits the converter sees on `mosi` at the falling edges of a frame, MSB first, are zero except the third one. The third bit equals the `nextChan` value sampled when the frame began. `mosi` changes only at the start of a frame and together with `sclk` rising edges.
- R4: `miso` is sampled once at each rising `sclk` edge. The 16 samples, first bit as MSB, are read as [15:14] leading zeros, [13] channel tag, [12] mode tag, [11:0] sample field. A good word is presented with `outChan`=[13], `outMode`=[12] and `outData`=[11:0] when `RES_BITS`=12.
- R5: With `RES_BITS`=10, `outData` is {field[11:2], 2'b00} and bits [1:0] must be zero.
- R6: A word whose bits [15:14] are not both zero, or whose bits [1:0] are not zero when `RES_BITS`=10, gives a `frameErr` pulse of exactly one cycle and no `outValid`.
- R7: From the second frame after reset on, the channel tag must equal the `nextChan` value sent in the previous frame; otherwise the word is handled as in R6. The first frame after reset has no such check.
- R8: `outValid` with its data stays stable until it is taken with `outReady`. No frame begins while `outValid` is high.
- R9: Between the end of one frame and the start of the next, `csN` stays high for at least `QUIET_CYC` system clocks.
- R10: Frames follow one another without any request from the host, whether the previous word was taken or dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| nextChan | input | 1 | Channel to request in the frame that starts next |
| csN | output | 1 | Active-low frame select to the converter |
| sclk | output | 1 | Serial clock to the converter, idles high |
| mosi | output | 1 | Serial request line to the converter |
| miso | input | 1 | Serial result line from the converter |
| outValid | output | 1 | A checked sample is available |
| outReady | input | 1 | Consumer takes the sample |
| outChan | output | 1 | Channel tag of the sample |
| outMode | output | 1 | Mode tag of the sample |
| outData | output | 12 | Sample, left-aligned |
| frameErr | output | 1 | One-cycle pulse when a word is dropped |

## Verification
Two things can meet in one cycle: the push of a finished word and the decision to start the next frame. They can meet because the quiet count runs down while the previous sample is still held. To provoke this, the bench holds `outReady` low past the end of the quiet count for some frames and releases it right away for others, so that the release and the end of the count land on the same or nearby cycles. It then judges three things on the ports: the held sample never changes, `csN` never falls while a sample is held, and the gap measured between frames is never shorter than `QUIET_CYC`. Error frames are mixed into the sweep to show that a dropped word starts the next frame without a handshake.

// File: rtl/adc2m_pkg.sv
package adc2m_pkg;
  localparam int FRAME_LEN = 16;

  typedef struct packed {
    logic start;   // open a frame: select low, load the request word
    logic toggle;  // flip the serial clock
    logic finish;  // close the frame: select high, judge the word
  } adc2m_strobe_t;

  typedef enum logic [1:0] {
    ST_QUIET = 2'd0,
    ST_RUN   = 2'd1,
    ST_PUSH  = 2'd2
  } adc2m_state_t;
endpackage

// File: rtl/adc2m_ctrl.sv
module adc2m_ctrl
  import adc2m_pkg::*;
#(
  parameter int HALF_DIV  = 2,
  parameter int QUIET_CYC = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          outBusy,
  output adc2m_strobe_t stb
);
  localparam int DIV_W = $clog2(HALF_DIV + 1);
  localparam int Q_W   = $clog2(QUIET_CYC + 1);
  localparam int EDGES = 2 * FRAME_LEN;
  localparam int E_W   = $clog2(EDGES + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);
  localparam logic [Q_W-1:0]   Q_LAST   = Q_W'(QUIET_CYC - 1);
  localparam logic [E_W-1:0]   E_LAST   = E_W'(EDGES - 1);

  adc2m_state_t     state;
  logic [DIV_W-1:0] divCnt;
  logic [Q_W-1:0]   quietCnt;
  logic [E_W-1:0]   edgeCnt;
  logic             quietDone;
  logic             halfDone;

  assign quietDone = (quietCnt == Q_LAST);
  assign halfDone  = (divCnt == DIV_LAST);

  always_comb begin
    stb        = '0;
    stb.start  = (state == ST_QUIET) && quietDone && !outBusy;
    stb.toggle = (state == ST_RUN) && halfDone;
    stb.finish = (state == ST_PUSH);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_QUIET;
      divCnt   <= '0;
      quietCnt <= '0;
      edgeCnt  <= '0;
    end else begin
      case (state)
        ST_QUIET: begin
          if (stb.start) begin
            state   <= ST_RUN;
            divCnt  <= '0;
            edgeCnt <= '0;
          end else if (!quietDone) begin
            quietCnt <= quietCnt + 1'b1;
          end
        end
        ST_RUN: begin
          if (halfDone) begin
            divCnt  <= '0;
            edgeCnt <= edgeCnt + 1'b1;
            if (edgeCnt == E_LAST) state <= ST_PUSH;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_PUSH: begin
          state    <= ST_QUIET;
          quietCnt <= '0;
        end
        default: state <= ST_QUIET;
      endcase
    end
  end
endmodule

// File: rtl/adc2m_dpath.sv
module adc2m_dpath
  import adc2m_pkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  adc2m_strobe_t stb,
  input  logic          nextChan,
  input  logic          miso,
  input  logic          outReady,
  output logic          csN,
  output logic          sclk,
  output logic          mosi,
  output logic          outValid,
  output logic          outChan,
  output logic          outMode,
  output logic [11:0]   outData,
  output logic          frameErr
);
  localparam int FIELD_W = 12;
  localparam int PAD     = FIELD_W - RES_BITS;

  logic [FRAME_LEN-1:0] txShift;
  logic [FRAME_LEN-1:0] rxShift;
  logic [FRAME_LEN-1:0] txWord;
  logic                 reqCur;
  logic                 prevReq;
  logic                 haveReq;
  logic [FIELD_W-1:0]   alignedData;
  logic                 trailOk;
  logic                 leadOk;
  logic                 chanOk;
  logic                 wordGood;

  // request word: channel choice sits in the third bit shifted out
  assign txWord = {2'b00, nextChan, 13'b0};

  generate
    if (PAD == 0) begin : g_full
      assign alignedData = rxShift[FIELD_W-1:0];
      assign trailOk     = 1'b1;
    end else begin : g_short
      assign alignedData = {rxShift[FIELD_W-1:PAD], {PAD{1'b0}}};
      assign trailOk     = (rxShift[PAD-1:0] == '0);
    end
  endgenerate

  assign leadOk   = (rxShift[15:14] == 2'b00);
  assign chanOk   = !haveReq || (rxShift[13] == prevReq);
  assign wordGood = leadOk && trailOk && chanOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csN     <= 1'b1;
      sclk    <= 1'b1;
      mosi    <= 1'b0;
      txShift <= '0;
      rxShift <= '0;
      reqCur  <= 1'b0;
      prevReq <= 1'b0;
      haveReq <= 1'b0;
    end else begin
      if (stb.start) begin
        csN     <= 1'b0;
        mosi    <= txWord[FRAME_LEN-1];
        txShift <= {txWord[FRAME_LEN-2:0], 1'b0};
        reqCur  <= nextChan;
      end
      if (stb.toggle) begin
        sclk <= ~sclk;
        if (!sclk) begin
          rxShift <= {rxShift[FRAME_LEN-2:0], miso};
          mosi    <= txShift[FRAME_LEN-1];
          txShift <= {txShift[FRAME_LEN-2:0], 1'b0};
        end
      end
      if (stb.finish) begin
        csN     <= 1'b1;
        prevReq <= reqCur;
        haveReq <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outChan  <= 1'b0;
      outMode  <= 1'b0;
      outData  <= '0;
      frameErr <= 1'b0;
    end else begin
      frameErr <= 1'b0;
      if (outValid && outReady) outValid <= 1'b0;
      if (stb.finish) begin
        if (wordGood) begin
          outValid <= 1'b1;
          outChan  <= rxShift[13];
          outMode  <= rxShift[12];
          outData  <= alignedData;
        end else begin
          frameErr <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/adc2_serial_master.sv
module adc2_serial_master
  import adc2m_pkg::*;
#(
  parameter int HALF_DIV  = 2,
  parameter int QUIET_CYC = 4,
  parameter int RES_BITS  = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        nextChan,
  output logic        csN,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        outValid,
  input  logic        outReady,
  output logic        outChan,
  output logic        outMode,
  output logic [11:0] outData,
  output logic        frameErr
);
  adc2m_strobe_t stb;

  adc2m_ctrl #(
    .HALF_DIV (HALF_DIV),
    .QUIET_CYC(QUIET_CYC)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .outBusy(outValid),
    .stb    (stb)
  );

  adc2m_dpath #(
    .RES_BITS(RES_BITS)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .nextChan(nextChan),
    .miso    (miso),
    .outReady(outReady),
    .csN     (csN),
    .sclk    (sclk),
    .mosi    (mosi),
    .outValid(outValid),
    .outChan (outChan),
    .outMode (outMode),
    .outData (outData),
    .frameErr(frameErr)
  );
endmodule

// File: rtl/adc2m_chk.sv
module adc2m_chk #(
  parameter int QUIET_CYC = 4
) (
  input logic        clk,
  input logic        rstN,
  input logic        csN,
  input logic        sclk,
  input logic        outValid,
  input logic        outReady,
  input logic        outChan,
  input logic        outMode,
  input logic [11:0] outData,
  input logic        frameErr
);
  localparam int CNT_W = $clog2(QUIET_CYC + 2) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] highCnt;
  logic [5:0]       riseCnt;
  logic             sclkQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      highCnt <= '0;
      riseCnt <= '0;
      sclkQ   <= 1'b1;
    end else begin
      sclkQ <= sclk;
      if (csN) begin
        riseCnt <= '0;
        if (highCnt != CNT_MAX) highCnt <= highCnt + 1'b1;
      end else begin
        highCnt <= '0;
        if (sclk && !sclkQ) riseCnt <= riseCnt + 1'b1;
      end
    end
  end

  p_idle_high_r2: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> sclk);

  p_sixteen_rises_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> riseCnt == 6'd16);

  p_quiet_gap_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> highCnt >= CNT_W'(QUIET_CYC));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) &&
                                 $stable(outChan) && $stable(outMode)));

  p_no_start_full_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> !$past(outValid));

  p_err_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |-> !outValid);

  p_err_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |=> !frameErr);
endmodule

bind adc2_serial_master adc2m_chk #(
  .QUIET_CYC(QUIET_CYC)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .csN     (csN),
  .sclk    (sclk),
  .outValid(outValid),
  .outReady(outReady),
  .outChan (outChan),
  .outMode (outMode),
  .outData (outData),
  .frameErr(frameErr)
);

// File: tb/dev_model.sv
module dev_model #(
  parameter bit RES10 = 1'b0
) (
  input  logic        csN,
  input  logic        sclk,
  input  logic        din,
  input  logic [11:0] injData,
  input  logic        injMode,
  input  logic [1:0]  injBad,
  output logic        dout,
  output logic [15:0] dinWord
);
  // injBad: 0 clean, 1 bad leading bit, 2 bad trailing bits (10-bit only), 3 flipped channel tag
  logic        chan   = 1'b0;
  logic [15:0] frame  = '0;
  logic [15:0] dinAcc = '0;
  int          k      = 0;

  initial begin
    dout    = 1'b0;
    dinWord = '0;
  end

  always @(negedge csN) begin
    frame[15:14] = (injBad == 2'd1) ? 2'b01 : 2'b00;
    frame[13]    = (injBad == 2'd3) ? ~chan : chan;
    frame[12]    = injMode;
    if (RES10) frame[11:0] = {injData[9:0], (injBad == 2'd2) ? 2'b10 : 2'b00};
    else       frame[11:0] = injData;
    k      = 0;
    dinAcc = '0;
  end

  always @(negedge sclk) begin
    if (!csN && k < 16) begin
      dout <= frame[15-k];
      dinAcc[15-k] = din;
      k = k + 1;
    end
  end

  always @(posedge csN) begin
    dinWord = dinAcc;
    chan    = dinAcc[13];
  end
endmodule

// File: tb/sim_adc2_serial_master.sv
module sim_adc2_serial_master;
  localparam int CLK_PERIOD = 10;
  localparam int HALF0 = 2, QUIET0 = 5;
  localparam int HALF1 = 1, QUIET1 = 3;
  localparam int NFRAMES = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        csN[2], sclk[2], mosi[2], miso[2], vld[2], rdy[2], nxt[2], ch[2], md[2], ferr[2];
  logic [11:0] dat[2];
  logic [11:0] injData[2];
  logic        injMode[2];
  logic [1:0]  injBad[2];
  logic [15:0] dinWord[2];

  int nChecks = 0, nErr = 0;
  int errCnt[2], errSeen[2];
  int gap[2], hiLen[2], falls[2];
  int clkViol[2], idleViol[2], fallViol[2], quietViol[2];
  logic pSclk[2], pCs[2];
  logic [11:0] curData[2];
  logic        curMode[2], curReq[2], curExp[2];
  logic [1:0]  curBad[2];

  adc2_serial_master #(.HALF_DIV(HALF0), .QUIET_CYC(QUIET0), .RES_BITS(12)) u0 (
    .clk(clk), .rstN(rstN), .nextChan(nxt[0]), .csN(csN[0]), .sclk(sclk[0]),
    .mosi(mosi[0]), .miso(miso[0]), .outValid(vld[0]), .outReady(rdy[0]),
    .outChan(ch[0]), .outMode(md[0]), .outData(dat[0]), .frameErr(ferr[0]));

  adc2_serial_master #(.HALF_DIV(HALF1), .QUIET_CYC(QUIET1), .RES_BITS(10)) u1 (
    .clk(clk), .rstN(rstN), .nextChan(nxt[1]), .csN(csN[1]), .sclk(sclk[1]),
    .mosi(mosi[1]), .miso(miso[1]), .outValid(vld[1]), .outReady(rdy[1]),
    .outChan(ch[1]), .outMode(md[1]), .outData(dat[1]), .frameErr(ferr[1]));

  dev_model #(.RES10(1'b0)) m0 (.csN(csN[0]), .sclk(sclk[0]), .din(mosi[0]),
    .injData(injData[0]), .injMode(injMode[0]), .injBad(injBad[0]),
    .dout(miso[0]), .dinWord(dinWord[0]));

  dev_model #(.RES10(1'b1)) m1 (.csN(csN[1]), .sclk(sclk[1]), .din(mosi[1]),
    .injData(injData[1]), .injMode(injMode[1]), .injBad(injBad[1]),
    .dout(miso[1]), .dinWord(dinWord[1]));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] genData(input int i);
    if (i == 0) return 12'h000;
    if (i == 1) return 12'hFFF;
    if (i == 2) return 12'hAAA;
    return 12'((i * 2731 + i * i * 7) % 4096);
  endfunction

  function automatic logic reqOf(input int i);
    return logic'((i % 3) == 0);
  endfunction

  function automatic logic [1:0] badOf(input int u, input int i);
    if (i == 6 || i == 18) return 2'd1;
    if (i == 10 || i == 21) return 2'd3;
    if (i == 14) return (u == 1) ? 2'd2 : 2'd0;
    return 2'd0;
  endfunction

  // error/timing monitor, sampled away from the active edge
  always @(negedge clk) begin
    for (int u = 0; u < 2; u++) begin
      if (ferr[u]) errCnt[u]++;
      if (!rstN) begin
        pSclk[u] = 1'b1; pCs[u] = 1'b1; gap[u] = 0; hiLen[u] = 0; falls[u] = 0;
      end else begin
        if (csN[u] && !sclk[u]) idleViol[u]++;
        if (sclk[u] !== pSclk[u] && !csN[u] && !pCs[u])
          if (gap[u] != ((u == 0) ? HALF0 : HALF1)) clkViol[u]++;
        if (sclk[u] !== pSclk[u] || csN[u] !== pCs[u]) gap[u] = 1;
        else gap[u]++;
        if (!sclk[u] && pSclk[u] && !csN[u]) falls[u]++;
        if (csN[u] && !pCs[u]) begin
          if (falls[u] != 16) fallViol[u]++;
          falls[u] = 0;
        end
        if (!csN[u] && pCs[u]) begin
          if (hiLen[u] < ((u == 0) ? QUIET0 : QUIET1)) quietViol[u]++;
          hiLen[u] = 0;
        end
        if (csN[u]) hiLen[u]++;
        pSclk[u] = sclk[u];
        pCs[u]   = csN[u];
      end
    end
  end

  // judge the pending frame, set up the next, then release the sample
  task automatic step(input int u, input logic [11:0] nData, input logic nMode,
                      input logic [1:0] nBad, input logic nReq, input int hold);
    int t;
    bit gotErr, expErr;
    logic [11:0] expData, keep;
    bit stable;
    t = 0;
    while (!vld[u] && errCnt[u] == errSeen[u] && t < 5000) begin
      @(negedge clk);
      t++;
    end
    chk(t < 5000, "R10 frame outcome seen", t, 0);
    gotErr = (errCnt[u] != errSeen[u]);
    errSeen[u] = errCnt[u];
    expErr = (curBad[u] == 2'd1) || (curBad[u] == 2'd3) || (curBad[u] == 2'd2 && u == 1);
    if (curBad[u] == 2'd3) chk(gotErr == expErr, "R7 channel tag mismatch", int'(gotErr), int'(expErr));
    else chk(gotErr == expErr, "R6 framing judgement", int'(gotErr), int'(expErr));
    chk(dinWord[u] == {2'b00, curReq[u], 13'b0}, "R3 request word", int'(dinWord[u]),
        int'({2'b00, curReq[u], 13'b0}));
    if (!gotErr) begin
      expData = (u == 0) ? curData[u] : {curData[u][9:0], 2'b00};
      if (u == 0) chk(dat[u] == expData, "R4 sample 12-bit", int'(dat[u]), int'(expData));
      else        chk(dat[u] == expData, "R5 sample 10-bit aligned", int'(dat[u]), int'(expData));
      chk(ch[u] == curExp[u], "R4 channel tag", int'(ch[u]), int'(curExp[u]));
      chk(md[u] == curMode[u], "R4 mode tag", int'(md[u]), int'(curMode[u]));
      if (hold > 0) begin
        keep = dat[u];
        stable = 1'b1;
        for (int h = 0; h < hold; h++) begin
          @(negedge clk);
          if (!vld[u] || !csN[u] || dat[u] != keep) stable = 1'b0;
        end
        chk(stable, "R8 held sample and stalled frame", int'(stable), 1);
      end
    end
    injData[u] = nData;
    injMode[u] = nMode;
    injBad[u]  = nBad;
    nxt[u]     = nReq;
    curExp[u]  = curReq[u];
    curReq[u]  = nReq;
    curData[u] = nData;
    curMode[u] = nMode;
    curBad[u]  = nBad;
    if (!gotErr) begin
      rdy[u] = 1'b1;
      @(negedge clk);
      rdy[u] = 1'b0;
    end
  endtask

  initial begin
    for (int u = 0; u < 2; u++) begin
      rdy[u] = 1'b0; errCnt[u] = 0; errSeen[u] = 0;
      clkViol[u] = 0; idleViol[u] = 0; fallViol[u] = 0; quietViol[u] = 0;
      gap[u] = 0; hiLen[u] = 0; falls[u] = 0; pSclk[u] = 1'b1; pCs[u] = 1'b1;
      injData[u] = genData(0); injMode[u] = 1'b0; injBad[u] = 2'd0;
      nxt[u] = reqOf(0);
      curData[u] = genData(0); curMode[u] = 1'b0; curBad[u] = 2'd0;
      curReq[u] = reqOf(0); curExp[u] = 1'b0;
    end
    repeat (3) @(negedge clk);
    for (int u = 0; u < 2; u++) begin
      chk(csN[u] && sclk[u] && !vld[u], "R1 state in reset", int'({csN[u], sclk[u], vld[u]}), 6);
    end
    rstN = 1'b1;
    @(negedge clk);
    for (int u = 0; u < 2; u++) begin
      chk(csN[u] && sclk[u] && !vld[u], "R1 state after reset", int'({csN[u], sclk[u], vld[u]}), 6);
    end
    for (int u = 0; u < 2; u++) begin
      for (int i = 1; i < NFRAMES; i++) begin
        step(u, genData(i), logic'(i % 2), badOf(u, i), reqOf(i),
             (i % 4 == 1) ? 0 : ((i % 4 == 2) ? 1 : ((i % 4 == 3) ? 8 : 25)));
      end
    end
    repeat (50) @(negedge clk);
    for (int u = 0; u < 2; u++) begin
      chk(clkViol[u] == 0, "R2 serial clock level length", clkViol[u], 0);
      chk(idleViol[u] == 0, "R2 clock high while deselected", idleViol[u], 0);
      chk(fallViol[u] == 0, "R2 sixteen edges per frame", fallViol[u], 0);
      chk(quietViol[u] == 0, "R9 quiet gap", quietViol[u], 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++;
    nErr++;
    $display("FAIL R10 watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule